// File: doc/BRIEF.md
# Bus Burst Efficiency Monitor

This block sits passively beside an AHB-style bus and sorts every clock cycle by what the bus spent it on. There are five classes: address overhead paid by a new transaction, a completed data beat, a stalled data phase (wait state), a BUSY slot and an idle cycle. Each class has its own cumulative counter. The block never drives the bus, and protocol checking is not part of it.

Alongside the totals, the monitor follows the currently open burst from its NONSEQ to its final data beat. When the burst closes, the monitor latches the beat count and the total cycle count of that burst, together with its burst type and direction, and pulses a done flag. Software can then compute amortisation as beats divided by cycles. Wait states appear only in the wait counter, so the burst-length effect and the slow-slave effect can be read apart. A long transfer that is split into several bursts shows one overhead cycle for each piece.

All counters are `CW` bits wide (default 32) and saturate. A synchronous clear returns every counter and every latched result to zero.

Top module: `bus_eff_mon`

## Requirements
- R1: Transfer codes on `htrans_i` are IDLE=00, BUSY=01, NONSEQ=10, SEQ=11. Each NONSEQ accepted with `hready_i` high adds exactly one to the overhead counter. SEQ adds no overhead.
- R2: A single transfer (NONSEQ then IDLE, no stalls) is latched as 1 beat in 2 cycles.
- R3: A burst of N beats without stalls is latched as N beats in N+1 cycles. For example, INCR4 gives 4 in 5 and INCR16 gives 16 in 17.
- R4: A data-phase cycle with `hready_i` low adds one to the wait counter and leaves the beat counter unchanged. It is included in the burst's cycle count. A cycle with `hready_i` low and no data phase pending adds no wait.
- R5: A burst closes when a transfer is accepted with `htrans_i` at IDLE or NONSEQ while the burst is open. The cycle after closing, `done_o` is high for exactly one cycle per closure, and the latched results are updated.
- R6: A NONSEQ with no IDLE before it closes the running burst and opens a new one in the same cycle. Each burst contributes one overhead cycle.
- R7: Accepted BUSY cycles increment only the busy counter. They never count as overhead, as a beat or as idle.
- R8: Every counter stops at its all-ones value and does not wrap.
- R9: When `clr_i` is high at a clock edge, all cumulative counters, all latched results and `done_o` become zero.
- R10: The latched results do not change between completions.
- R11: A cycle with IDLE on `htrans_i` and no data phase pending increments the idle counter.
- R12: `last_burst_o` and `last_write_o` report `hburst_i` and `hwrite_i` as they were sampled at the NONSEQ of the latched burst. INCR4 is 011 and INCR16 is 111.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| clr_i | input | 1 | Synchronous clear of all counters and results |
| htrans_i | input | 2 | Observed transfer type |
| hburst_i | input | 3 | Observed burst type |
| hready_i | input | 1 | Observed transfer-done / ready |
| hwrite_i | input | 1 | Observed direction, 1 = write |
| ovh_cnt_o | output | CW | Cumulative address-overhead cycles |
| beat_cnt_o | output | CW | Cumulative completed data beats |
| wait_cnt_o | output | CW | Cumulative wait-state cycles |
| busy_cnt_o | output | CW | Cumulative BUSY cycles |
| idle_cnt_o | output | CW | Cumulative idle cycles |
| last_beats_o | output | CW | Beats of the last closed burst |
| last_cycles_o | output | CW | Total cycles of the last closed burst |
| last_burst_o | output | 3 | Burst type of the last closed burst |
| last_write_o | output | 1 | Direction of the last closed burst |
| done_o | output | 1 | One-cycle pulse per burst closure |

## Verification
The bench goes after the cycle where one burst's last beat and the next burst's NONSEQ coincide. A monitor that treated that cycle as purely one thing would report a split INCR8 as one overhead or as 5 beats in 4 cycles. Stalls inside and at the end of a burst are driven to catch a design that counts a stalled data phase as a beat, or that closes the burst while the final beat is still stalled. BUSY in mid-burst checks that the beat count is not inflated and that no overhead is added. A long run of back-to-back singles on a narrow build pushes the counters past all-ones, where a wrapping counter would read small again.

// File: rtl/bem_pkg.sv
package bem_pkg;
  localparam logic [1:0] TR_IDLE = 2'b00;
  localparam logic [1:0] TR_BUSY = 2'b01;
  localparam logic [1:0] TR_NSEQ = 2'b10;
  localparam logic [1:0] TR_SEQ  = 2'b11;

  // event vector positions
  localparam int unsigned EV_IDLE = 0;
  localparam int unsigned EV_BUSY = 1;
  localparam int unsigned EV_WAIT = 2;
  localparam int unsigned EV_BEAT = 3;
  localparam int unsigned EV_OVH  = 4;
  localparam int unsigned NUM_EV  = 5;
endpackage

// File: rtl/bem_classify.sv
module bem_classify
  import bem_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        htrans_i,
  input  logic              hready_i,
  output logic [NUM_EV-1:0] ev_o
);
  // a data phase is outstanding after an accepted NONSEQ or SEQ
  logic dphase_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        dphase_q <= 1'b0;
    else if (hready_i) dphase_q <= htrans_i[1];
  end

  always_comb begin
    ev_o          = '0;
    ev_o[EV_BEAT] = dphase_q && hready_i;
    ev_o[EV_WAIT] = dphase_q && !hready_i;
    ev_o[EV_OVH]  = hready_i && (htrans_i == TR_NSEQ);
    ev_o[EV_BUSY] = hready_i && (htrans_i == TR_BUSY);
    ev_o[EV_IDLE] = !dphase_q && (htrans_i == TR_IDLE);
  end
endmodule

// File: rtl/bem_sat_cnt.sv
module bem_sat_cnt #(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] q_o
);
  localparam logic [W-1:0] TOP = '1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    q_o <= '0;
    else if (clr_i)                q_o <= '0;
    else if (inc_i && q_o != TOP)  q_o <= q_o + 1'b1;
  end
endmodule

// File: rtl/bem_burst_track.sv
module bem_burst_track
  import bem_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [1:0]    htrans_i,
  input  logic [2:0]    hburst_i,
  input  logic          hready_i,
  input  logic          hwrite_i,
  input  logic          beat_i,
  output logic [CW-1:0] last_beats_o,
  output logic [CW-1:0] last_cycles_o,
  output logic [2:0]    last_burst_o,
  output logic          last_write_o,
  output logic          done_o
);
  localparam logic [CW-1:0] TOP = '1;

  logic          open_q;
  logic [CW-1:0] beats_q, cyc_q, beats_nx, cyc_nx;
  logic [2:0]    kind_q;
  logic          wr_q;
  logic          start_hit, close_hit;

  assign start_hit = hready_i && (htrans_i == TR_NSEQ);
  assign close_hit = open_q && hready_i &&
                     (htrans_i == TR_IDLE || htrans_i == TR_NSEQ);
  assign beats_nx  = (beat_i && beats_q != TOP) ? beats_q + 1'b1 : beats_q;
  assign cyc_nx    = (cyc_q != TOP) ? cyc_q + 1'b1 : cyc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0; beats_q <= '0; cyc_q <= '0; kind_q <= '0; wr_q <= 1'b0;
      last_beats_o <= '0; last_cycles_o <= '0; last_burst_o <= '0;
      last_write_o <= 1'b0; done_o <= 1'b0;
    end else if (clr_i) begin
      open_q <= 1'b0; beats_q <= '0; cyc_q <= '0; kind_q <= '0; wr_q <= 1'b0;
      last_beats_o <= '0; last_cycles_o <= '0; last_burst_o <= '0;
      last_write_o <= 1'b0; done_o <= 1'b0;
    end else begin
      done_o <= close_hit;
      if (close_hit) begin
        last_beats_o  <= beats_nx;
        last_cycles_o <= cyc_nx;
        last_burst_o  <= kind_q;
        last_write_o  <= wr_q;
      end
      if (start_hit) begin
        open_q  <= 1'b1;
        beats_q <= '0;
        cyc_q   <= {{(CW-1){1'b0}}, 1'b1};
        kind_q  <= hburst_i;
        wr_q    <= hwrite_i;
      end else if (close_hit) begin
        open_q  <= 1'b0;
      end else if (open_q) begin
        beats_q <= beats_nx;
        cyc_q   <= cyc_nx;
      end
    end
  end
endmodule

// File: rtl/bus_eff_mon.sv
module bus_eff_mon
  import bem_pkg::*;
#(
  parameter int unsigned CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr_i,
  input  logic [1:0]    htrans_i,
  input  logic [2:0]    hburst_i,
  input  logic          hready_i,
  input  logic          hwrite_i,
  output logic [CW-1:0] ovh_cnt_o,
  output logic [CW-1:0] beat_cnt_o,
  output logic [CW-1:0] wait_cnt_o,
  output logic [CW-1:0] busy_cnt_o,
  output logic [CW-1:0] idle_cnt_o,
  output logic [CW-1:0] last_beats_o,
  output logic [CW-1:0] last_cycles_o,
  output logic [2:0]    last_burst_o,
  output logic          last_write_o,
  output logic          done_o
);
  logic [NUM_EV-1:0] ev;
  logic [CW-1:0]     cnt [NUM_EV];

  bem_classify u_cls (
    .clk(clk), .rst_n(rst_n), .htrans_i(htrans_i), .hready_i(hready_i), .ev_o(ev)
  );

  for (genvar g = 0; g < NUM_EV; g++) begin : g_cnt
    bem_sat_cnt #(.W(CW)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .inc_i(ev[g]), .q_o(cnt[g])
    );
  end

  assign ovh_cnt_o  = cnt[EV_OVH];
  assign beat_cnt_o = cnt[EV_BEAT];
  assign wait_cnt_o = cnt[EV_WAIT];
  assign busy_cnt_o = cnt[EV_BUSY];
  assign idle_cnt_o = cnt[EV_IDLE];

  bem_burst_track #(.CW(CW)) u_trk (
    .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .htrans_i(htrans_i),
    .hburst_i(hburst_i), .hready_i(hready_i), .hwrite_i(hwrite_i),
    .beat_i(ev[EV_BEAT]), .last_beats_o(last_beats_o),
    .last_cycles_o(last_cycles_o), .last_burst_o(last_burst_o),
    .last_write_o(last_write_o), .done_o(done_o)
  );
endmodule

// File: rtl/bem_chk.sv
module bem_chk #(
  parameter int unsigned CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          clr_i,
  input logic [1:0]    htrans_i,
  input logic          hready_i,
  input logic [CW-1:0] ovh_cnt_o,
  input logic [CW-1:0] beat_cnt_o,
  input logic [CW-1:0] busy_cnt_o,
  input logic [CW-1:0] last_beats_o,
  input logic [CW-1:0] last_cycles_o,
  input logic          done_o
);
  localparam logic [CW-1:0] TOP = '1;

  assert_seq_no_ovh_R1: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (hready_i && htrans_i == 2'b11) |=> $stable(ovh_cnt_o));

  assert_cycles_exceed_beats_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && last_cycles_o != TOP) |-> (last_cycles_o > last_beats_o));

  assert_stall_no_beat_R4: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    !hready_i |=> $stable(beat_cnt_o));

  assert_busy_only_on_busy_R7: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (htrans_i != 2'b01) |=> $stable(busy_cnt_o));

  assert_no_overflow_R8: assert property (@(posedge clk) disable iff (!rst_n || clr_i)
    (ovh_cnt_o == TOP) |=> (ovh_cnt_o == TOP));

  assert_clear_zeroes_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (ovh_cnt_o == '0 && beat_cnt_o == '0 && last_cycles_o == '0 && !done_o));

  assert_latched_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!done_o && !$past(clr_i)) |-> ($stable(last_cycles_o) && $stable(last_beats_o)));
endmodule

bind bus_eff_mon bem_chk #(.CW(CW)) chk_i (
  .clk(clk), .rst_n(rst_n), .clr_i(clr_i), .htrans_i(htrans_i),
  .hready_i(hready_i), .ovh_cnt_o(ovh_cnt_o), .beat_cnt_o(beat_cnt_o),
  .busy_cnt_o(busy_cnt_o), .last_beats_o(last_beats_o),
  .last_cycles_o(last_cycles_o), .done_o(done_o)
);

// File: tb/bus_eff_mon_tb_top.sv
`timescale 1ns/1ps
module bus_eff_mon_tb_top;
  localparam int unsigned CW = 5;
  localparam logic [1:0] ID = 2'b00, BS = 2'b01, NS = 2'b10, SQ = 2'b11;

  logic clk = 1'b0, rst_n = 1'b0, clr = 1'b0;
  logic [1:0] htrans = ID;
  logic [2:0] hburst = 3'b000;
  logic hready = 1'b1, hwrite = 1'b0;
  logic [CW-1:0] ovh, beat, wt, busy, idle, lbeats, lcyc;
  logic [2:0] lburst;
  logic lwr, done;
  int tests = 0, fails = 0, done_cnt = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  bus_eff_mon #(.CW(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .clr_i(clr), .htrans_i(htrans), .hburst_i(hburst),
    .hready_i(hready), .hwrite_i(hwrite), .ovh_cnt_o(ovh), .beat_cnt_o(beat),
    .wait_cnt_o(wt), .busy_cnt_o(busy), .idle_cnt_o(idle),
    .last_beats_o(lbeats), .last_cycles_o(lcyc), .last_burst_o(lburst),
    .last_write_o(lwr), .done_o(done)
  );

  always @(negedge clk) if (rst_n && done) done_cnt++;

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input logic [1:0] tr, input logic rdy);
    htrans = tr; hready = rdy;
    @(negedge clk);
  endtask

  task automatic do_clr();
    clr = 1'b1;
    cyc(ID, 1'b1);
    clr = 1'b0;
    done_cnt = 0;
  endtask

  task automatic t_reset();
    chk("R9 reset ovh", ovh, 0);
    chk("R9 reset last_cycles", lcyc, 0);
    chk("R5 reset done", done, 0);
  endtask

  task automatic t_single();
    do_clr(); hburst = 3'b000; hwrite = 1'b0;
    cyc(NS, 1); cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R1 single overhead", ovh, 1);
    chk("R2 single beats", lbeats, 1);
    chk("R2 single cycles", lcyc, 2);
    chk("R11 idle count", idle, 2);
    chk("R5 single done pulses", done_cnt, 1);
  endtask

  task automatic t_incr4();
    do_clr(); hburst = 3'b011; hwrite = 1'b1;
    cyc(NS, 1); cyc(SQ, 1); cyc(SQ, 1); cyc(SQ, 1);
    cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R1 incr4 overhead", ovh, 1);
    chk("R3 incr4 beats", lbeats, 4);
    chk("R3 incr4 cycles", lcyc, 5);
    chk("R12 incr4 kind", lburst, 3);
    chk("R12 incr4 write", lwr, 1);
    chk("R5 incr4 done pulses", done_cnt, 1);
  endtask

  task automatic t_waits();
    do_clr(); hburst = 3'b001; hwrite = 1'b0;
    cyc(NS, 1); cyc(SQ, 0); cyc(SQ, 1); cyc(ID, 0); cyc(ID, 1);
    cyc(ID, 1); cyc(ID, 1);
    chk("R4 wait count", wt, 2);
    chk("R4 beat count", beat, 2);
    chk("R4 burst cycles incl waits", lcyc, 5);
    chk("R4 burst beats", lbeats, 2);
  endtask

  task automatic t_split();
    do_clr(); hburst = 3'b011;
    cyc(NS, 1); cyc(SQ, 1); cyc(SQ, 1); cyc(SQ, 1);
    cyc(NS, 1); cyc(SQ, 1); cyc(SQ, 1); cyc(SQ, 1);
    cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R6 split overhead", ovh, 2);
    chk("R6 split beats", beat, 8);
    chk("R6 split closures", done_cnt, 2);
    chk("R6 split last beats", lbeats, 4);
    chk("R6 split last cycles", lcyc, 5);
  endtask

  task automatic t_busy();
    do_clr(); hburst = 3'b001;
    cyc(NS, 1); cyc(BS, 1); cyc(SQ, 1); cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R7 busy count", busy, 1);
    chk("R7 busy overhead", ovh, 1);
    chk("R7 busy beats", lbeats, 2);
    chk("R7 busy cycles", lcyc, 4);
    chk("R11 idle after busy burst", idle, 2);
  endtask

  task automatic t_hold();
    // continues from t_busy without clearing
    cyc(ID, 0); cyc(ID, 0); cyc(ID, 0); cyc(ID, 1); cyc(ID, 1);
    chk("R10 hold beats", lbeats, 2);
    chk("R10 hold cycles", lcyc, 4);
    chk("R10 no extra done", done_cnt, 1);
    chk("R4 stall without data phase", wt, 0);
  endtask

  task automatic t_clear();
    do_clr();
    cyc(ID, 1);
    chk("R9 clear ovh", ovh, 0);
    chk("R9 clear beat", beat, 0);
    chk("R9 clear busy", busy, 0);
    chk("R9 clear last beats", lbeats, 0);
    chk("R9 clear last cycles", lcyc, 0);
  endtask

  task automatic t_saturate();
    do_clr(); hburst = 3'b000;
    for (int i = 0; i < 40; i++) cyc(NS, 1);
    cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R8 ovh saturated", ovh, 31);
    chk("R8 beat saturated", beat, 31);
    chk("R6 back-to-back single cycles", lcyc, 2);
  endtask

  task automatic t_incr16();
    do_clr(); hburst = 3'b111; hwrite = 1'b0;
    cyc(NS, 1);
    for (int i = 0; i < 15; i++) cyc(SQ, 1);
    cyc(ID, 1); cyc(ID, 1); cyc(ID, 1);
    chk("R3 incr16 beats", lbeats, 16);
    chk("R3 incr16 cycles", lcyc, 17);
    chk("R12 incr16 kind", lburst, 7);
    chk("R12 incr16 write", lwr, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single();
    t_incr4();
    t_waits();
    t_split();
    t_busy();
    t_hold();
    t_clear();
    t_saturate();
    t_incr16();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule